// File: doc/BRIEF.md
# ISA I/O Address Window Decoder

This block decides whether a peripheral sitting on a 20-bit ISA-style bus claims an I/O read or write cycle. It compares the low 16 address lines against a programmable I/O base register. It asserts a respond output when the address falls inside the peripheral's 16-byte window while an active-low I/O read or write strobe is asserted. The chip-select input and the memory-mode enable play no part in this decision.

The base register starts at 0x0300 on reset. One configuration word may then replace it, through a valid/absent handshake, but only if the word carries the expected start marker and a matching 8-bit checksum. Until that step completes or is declared absent, a busy flag holds the decoder silent. Afterwards, software may rewrite the base through a small register write port at offset 0x020. Every accepted base value has its low four bits cleared, so the window is always aligned. The respond signal is combinational, and it is also provided as a registered copy for synchronous consumers.

Top module: `io_window_decoder`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `base_o` is 0x0300, `cfg_busy` is 1 and `io_hit` is 0.
- R2: `cfg_busy` falls one cycle after a cycle in which it is high and either `cfg_valid` or `cfg_absent` is 1. It does not rise again until the next reset. While it is high, `io_hit` is 0.
- R3: A configuration load is accepted when `cfg_mark` equals 16'h5A3C and `cfg_csum` equals the modulo-256 sum of the four bytes `cfg_mark[15:8]`, `cfg_mark[7:0]`, `cfg_base[15:8]` and `cfg_base[7:0]`. The base then becomes `cfg_base` with bits [3:0] cleared.
- R4: A load with a wrong marker or a wrong checksum, or a cycle with `cfg_absent`, leaves the base at 0x0300.
- R5: The comparison uses `sa[15:4]` against base bits [15:4]. `sa[19:16]` and `sa[3:0]` have no effect, so the window covers 16 consecutive byte addresses starting at the base.
- R6: `io_hit` is 1 only when `ior_n` or `iow_n` is 0 in the same cycle, busy is low and the address matches. It is 0 when both strobes are 1.
- R7: `cs_n` and `mem_en` have no effect on `io_hit`.
- R8: A cycle with `reg_we`=1 and `reg_ofs`=10'h020 sets the base to `reg_wdata` with bits [3:0] cleared, from the next cycle on. This works whether or not busy is high, and it takes priority over a configuration load in the same cycle. Writes to any other offset leave the base unchanged.
- R9: `io_hit_q` equals the value `io_hit` had in the previous cycle, and it is 0 on the first cycle after reset.
- R10: `base_o` always shows the base value that the comparator uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sa | input | 20 | Bus address lines |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| cs_n | input | 1 | Chip select, ignored on I/O cycles |
| mem_en | input | 1 | Memory-mode enable, ignored by this decoder |
| cfg_valid | input | 1 | Configuration word present this cycle |
| cfg_absent | input | 1 | No configuration available; finish the load step |
| cfg_mark | input | 16 | Configuration start marker |
| cfg_base | input | 16 | Configuration base value |
| cfg_csum | input | 8 | Configuration checksum byte |
| reg_we | input | 1 | Register write strobe |
| reg_ofs | input | 10 | Register write offset |
| reg_wdata | input | 16 | Register write data |
| io_hit | output | 1 | Combinational I/O respond |
| io_hit_q | output | 1 | Respond delayed by one clock |
| cfg_busy | output | 1 | Post-reset load step still pending |
| base_o | output | 16 | Current I/O base |

## Verification
Address sweeps run across each window edge (base−1, base, base+15, base+16) with a read strobe, with a write strobe and with no strobe. These separate an off-by-one window, a comparison that includes the low nibble, and a strobe gating that is missing or inverted. The same sweeps are repeated with the upper address nibble set and with chip select and memory enable toggled, which exposes any leakage from ignored inputs. Configuration loads are tried with a good word, a bad checksum, a bad marker that has a self-consistent sum, and the absent path. Software writes go to the right offset, to a wrong offset and in the same cycle as a load, so that acceptance and priority are told apart.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

   localparam int unsigned CFG_W = 16;

   // modulo-256 sum over the bytes of the marker and the base
   function automatic logic [7:0] cfg_sum(input logic [CFG_W-1:0] mark,
                                          input logic [CFG_W-1:0] base);
      logic [7:0] acc;
      acc = 8'h00;
      for (int i = 0; i < CFG_W / 8; i++) begin
         acc = acc + mark[i*8 +: 8] + base[i*8 +: 8];
      end
      return acc;
   endfunction

endpackage

// File: rtl/iodec_cfg_check.sv
module iodec_cfg_check
   import iodec_pkg::*;
#(
   parameter logic [CFG_W-1:0] START_MARK = 16'h5A3C
) (
   input  logic [CFG_W-1:0] mark,
   input  logic [CFG_W-1:0] base,
   input  logic [7:0]       csum,
   output logic             ok
);
   logic mark_ok;
   logic sum_ok;

   always_comb begin
      mark_ok = (mark == START_MARK);
      sum_ok  = (cfg_sum(mark, base) == csum);
      ok      = mark_ok && sum_ok;
   end
endmodule

// File: rtl/iodec_base_reg.sv
module iodec_base_reg #(
   parameter int unsigned W        = 16,
   parameter int unsigned ALIGN    = 4,
   parameter int unsigned OFS_W    = 10,
   parameter logic [W-1:0] RST_VAL = 16'h0300,
   parameter logic [OFS_W-1:0] BASE_OFS = 10'h020
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_valid,
   input  logic             cfg_absent,
   input  logic             cfg_ok,
   input  logic [W-1:0]     cfg_base,
   input  logic             reg_we,
   input  logic [OFS_W-1:0] reg_ofs,
   input  logic [W-1:0]     reg_wdata,
   output logic [W-1:0]     base,
   output logic             busy
);
   localparam int unsigned LOWMASK = (1 << ALIGN) - 1;
   localparam logic [W-1:0] KEEP   = ~W'(LOWMASK);

   if (ALIGN >= W) begin : g_bad_align
      $error("iodec_base_reg: ALIGN must be below W");
   end
   if ((RST_VAL & ~KEEP) != '0) begin : g_bad_rst
      $error("iodec_base_reg: RST_VAL must be aligned");
   end

   logic sw_hit;
   logic cfg_done;
   logic cfg_take;

   always_comb begin
      sw_hit   = reg_we && (reg_ofs == BASE_OFS);
      cfg_done = busy && (cfg_valid || cfg_absent);
      cfg_take = busy && cfg_valid && cfg_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= RST_VAL;
         busy <= 1'b1;
      end else begin
         if (cfg_done) busy <= 1'b0;
         if (sw_hit)        base <= reg_wdata & KEEP;
         else if (cfg_take) base <= cfg_base & KEEP;
      end
   end

   // R2
   busy_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !busy);

   // R4
   bad_load_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (cfg_valid || cfg_absent) && !cfg_ok && !sw_hit) |=> $stable(base));

   // R8
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !sw_hit) |=> $stable(base));

   // R8
   sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_hit |=> (base == ($past(reg_wdata) & KEEP)));
endmodule

// File: rtl/iodec_addr_match.sv
module iodec_addr_match #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned CMP_W  = 16,
   parameter int unsigned ALIGN  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] sa,
   input  logic [CMP_W-1:0]  base,
   input  logic              ior_n,
   input  logic              iow_n,
   input  logic              busy,
   output logic              hit
);
   if (CMP_W > ADDR_W) begin : g_bad_cmp
      $error("iodec_addr_match: CMP_W exceeds ADDR_W");
   end

   logic strobe;
   logic eq;

   assign strobe = !ior_n || !iow_n;

   if (ALIGN == 0) begin : g_full
      assign eq = (sa[CMP_W-1:0] == base);
   end else begin : g_aligned
      logic unused_lo;
      assign eq        = (sa[CMP_W-1:ALIGN] == base[CMP_W-1:ALIGN]);
      assign unused_lo = ^{sa[ALIGN-1:0], base[ALIGN-1:0]};
   end

   if (ADDR_W > CMP_W) begin : g_upper
      logic unused_hi;
      assign unused_hi = ^sa[ADDR_W-1:CMP_W];
   end

   assign hit = strobe && !busy && eq;

   // R2
   busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !hit);

   // R6
   no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ior_n && iow_n) |-> !hit);
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
   import iodec_pkg::*;
#(
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned CMP_W      = 16,
   parameter int unsigned ALIGN      = 4,
   parameter int unsigned OFS_W      = 10,
   parameter logic [15:0] RST_BASE   = 16'h0300,
   parameter logic [9:0]  BASE_OFS   = 10'h020,
   parameter logic [15:0] START_MARK = 16'h5A3C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] sa,
   input  logic              ior_n,
   input  logic              iow_n,
   input  logic              cs_n,
   input  logic              mem_en,
   input  logic              cfg_valid,
   input  logic              cfg_absent,
   input  logic [15:0]       cfg_mark,
   input  logic [15:0]       cfg_base,
   input  logic [7:0]        cfg_csum,
   input  logic              reg_we,
   input  logic [OFS_W-1:0]  reg_ofs,
   input  logic [CMP_W-1:0]  reg_wdata,
   output logic              io_hit,
   output logic              io_hit_q,
   output logic              cfg_busy,
   output logic [CMP_W-1:0]  base_o
);
   if (CMP_W != CFG_W) begin : g_bad_w
      $error("io_window_decoder: CMP_W must match configuration width");
   end

   logic cfg_ok;
   logic unused_side;

   // chip select and memory enable do not take part in I/O decoding
   assign unused_side = cs_n ^ mem_en;

   iodec_cfg_check #(.START_MARK(START_MARK)) u_chk (
      .mark (cfg_mark),
      .base (cfg_base),
      .csum (cfg_csum),
      .ok   (cfg_ok)
   );

   iodec_base_reg #(
      .W(CMP_W), .ALIGN(ALIGN), .OFS_W(OFS_W),
      .RST_VAL(CMP_W'(RST_BASE)), .BASE_OFS(OFS_W'(BASE_OFS))
   ) u_base (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_valid  (cfg_valid),
      .cfg_absent (cfg_absent),
      .cfg_ok     (cfg_ok),
      .cfg_base   (cfg_base),
      .reg_we     (reg_we),
      .reg_ofs    (reg_ofs),
      .reg_wdata  (reg_wdata),
      .base       (base_o),
      .busy       (cfg_busy)
   );

   iodec_addr_match #(.ADDR_W(ADDR_W), .CMP_W(CMP_W), .ALIGN(ALIGN)) u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .sa    (sa),
      .base  (base_o),
      .ior_n (ior_n),
      .iow_n (iow_n),
      .busy  (cfg_busy),
      .hit   (io_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) io_hit_q <= 1'b0;
      else        io_hit_q <= io_hit;
   end

   // R9
   hit_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (io_hit_q == $past(io_hit)));
endmodule

// File: tb/io_window_decoder_tb.sv
module io_window_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] sa = '0;
   logic        ior_n = 1'b1, iow_n = 1'b1, cs_n = 1'b1, mem_en = 1'b0;
   logic        cfg_valid = 1'b0, cfg_absent = 1'b0;
   logic [15:0] cfg_mark = '0, cfg_base = '0;
   logic [7:0]  cfg_csum = '0;
   logic        reg_we = 1'b0;
   logic [9:0]  reg_ofs = '0;
   logic [15:0] reg_wdata = '0;
   logic        io_hit, io_hit_q, cfg_busy;
   logic [15:0] base_o;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   // behavioural reference state
   int  m_base = 'h300;
   bit  m_busy = 1;
   bit  m_hq   = 0;

   always #2 clk = ~clk;

   io_window_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .sa(sa), .ior_n(ior_n), .iow_n(iow_n),
      .cs_n(cs_n), .mem_en(mem_en), .cfg_valid(cfg_valid), .cfg_absent(cfg_absent),
      .cfg_mark(cfg_mark), .cfg_base(cfg_base), .cfg_csum(cfg_csum),
      .reg_we(reg_we), .reg_ofs(reg_ofs), .reg_wdata(reg_wdata),
      .io_hit(io_hit), .io_hit_q(io_hit_q), .cfg_busy(cfg_busy), .base_o(base_o)
   );

   function automatic int byte_sum(int a, int b);
      return ((a >> 8) + (a & 255) + (b >> 8) + (b & 255)) & 255;
   endfunction

   task automatic check(string req, int act, int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   // compare every cycle away from the edge, then advance the model
   always @(negedge clk) begin
      bit exp_hit;
      if (!rst_n) begin
         m_base = 'h300; m_busy = 1; m_hq = 0;
      end
      exp_hit = !m_busy && (!ior_n || !iow_n) && ((int'(sa[15:0]) >> 4) == (m_base >> 4));
      check("R5,R6,R7 io_hit", int'(io_hit), int'(exp_hit));
      check("R9 io_hit_q", int'(io_hit_q), int'(m_hq));
      check("R1,R2 cfg_busy", int'(cfg_busy), int'(m_busy));
      check("R10,R3,R4,R8 base_o", int'(base_o), m_base);
      if (rst_n) begin
         m_hq = exp_hit;
         if (reg_we && reg_ofs == 10'h020) m_base = int'(reg_wdata) & 'hFFF0;
         else if (m_busy && cfg_valid && cfg_mark == 16'h5A3C &&
                  int'(cfg_csum) == byte_sum(int'(cfg_mark), int'(cfg_base)))
            m_base = int'(cfg_base) & 'hFFF0;
         if (m_busy && (cfg_valid || cfg_absent)) m_busy = 0;
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus(logic [19:0] a, bit rd, bit wr);
      sa = a; ior_n = !rd; iow_n = !wr;
      tick();
   endtask

   // R5 R6 R7: sweep each side of the window with both strobes and none
   task automatic sweep(int b);
      for (int k = -2; k < 19; k++) begin
         logic [19:0] a = 20'(b + k);
         bus(a, 1, 0);
         bus(a, 0, 1);
         bus(a, 0, 0);
         cs_n = !cs_n; mem_en = !mem_en;
         bus(a | 20'hF0000, 1, 0);
      end
      ior_n = 1; iow_n = 1;
   endtask

   task automatic do_reset();
      rst_n = 0; cfg_valid = 0; cfg_absent = 0; reg_we = 0;
      tick(3);
      rst_n = 1;
   endtask

   task automatic load(int mark, int b, int cs);
      cfg_mark = 16'(mark); cfg_base = 16'(b); cfg_csum = 8'(cs); cfg_valid = 1;
      tick();
      cfg_valid = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog expired: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R1 R2: strobe at the default base while busy must stay silent
      bus(20'h00300, 1, 0);
      bus(20'h00305, 0, 1);
      tick(2);
      // R4: bad checksum keeps default
      load('h5A3C, 'h0A30, byte_sum('h5A3C, 'h0A30) ^ 1);
      sweep('h300);
      // R8: wrong offset ignored, right offset lands aligned
      reg_we = 1; reg_ofs = 10'h022; reg_wdata = 16'h1234; tick();
      reg_ofs = 10'h020; reg_wdata = 16'h0287; tick();
      reg_we = 0;
      sweep('h280);
      // R3: good load
      do_reset();
      load('h5A3C, 'h0A3B, byte_sum('h5A3C, 'h0A3B));
      sweep('hA30);
      // R4: bad marker with self-consistent sum
      do_reset();
      load('h5A3D, 'h0A30, byte_sum('h5A3D, 'h0A30));
      sweep('h300);
      // R4 R2: absent path
      do_reset();
      tick(2);
      cfg_absent = 1; tick(); cfg_absent = 0;
      bus(20'h0030F, 1, 0);
      bus(20'h00310, 1, 0);
      // R8: software write wins over load in the same cycle
      do_reset();
      reg_we = 1; reg_ofs = 10'h020; reg_wdata = 16'hBEEF;
      load('h5A3C, 'h0A30, byte_sum('h5A3C, 'h0A30));
      reg_we = 0;
      sweep('hBEE0);
      tick(2);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule